// File: doc/BRIEF.md
# Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial bit stream. A host places a character in a one-entry holding register. When the shifter is free, the character moves into it and goes out on the line in this order: a low start bit, the data bits least significant first, an optional parity bit, and a high stop period. The host can load the next character while the current one is still shifting, so consecutive characters leave with no idle gap between them.

Timing comes from a single-cycle rate enable that pulses at `OVERSAMPLE` times the bit rate. Frame settings come from a line-control input: the data length, parity on or off, even or odd parity, a stop-length select and a break force. These settings are sampled when a character moves into the shifter. A holding-empty flag and a sticky interrupt request tell the host when it may write again. A transmitter-empty flag reports that nothing at all remains to send.

Top module: `async_tx`

## Requirements
- R1: After reset the line is high (mark), `hold_empty`=1, `irq`=0 and `tx_empty`=1. While `tx_empty`=1 and `brk`=0, `txd` stays high.
- R2: A character starts with a low start bit, followed by its data bits least significant first. The number of data bits is set by `char_len`: 00=5, 01=6, 10=7, 11=8.
- R3: With `par_en`=1, one parity bit follows the data bits. With `par_even`=1 the data bits and the parity bit together hold an even number of ones; with `par_even`=0 they hold an odd number. With `par_en`=0 no parity bit is sent.
- R4: The stop period is high. With `stop_sel`=0 it lasts 1 bit time (16 enable pulses). With `stop_sel`=1 it lasts 1.5 bit times (24 pulses) when `char_len`=00, and 2 bit times (32 pulses) otherwise.
- R5: The start, data and parity bits each last exactly `OVERSAMPLE` pulses of `tick`. The count holds between pulses.
- R6: If the holding register is full when a stop period ends, the next start bit begins right away, with no idle time.
- R7: A write (`wr_en`=1) clears `hold_empty` and `irq` on the next clock. When the character moves into the shifter, `hold_empty` and `irq` both go to 1.
- R8: `tx_empty` is 1 only when the holding register is empty and the shifter is idle.
- R9: While `brk`=1, `txd` is low. When `brk` returns to 0 on an idle line, `txd` goes high again.
- R10: Line settings are captured when a character moves into the shifter. Changing them while that character is shifting does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Rate enable, `OVERSAMPLE` pulses per bit |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| char_len | input | 2 | Data length select (00=5 … 11=8) |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| stop_sel | input | 1 | 0 = one stop bit, 1 = 1.5 or 2 stop bits |
| brk | input | 1 | Forces the line low |
| txd | output | 1 | Serial output |
| hold_empty | output | 1 | Holding register can accept a character |
| irq | output | 1 | Holding-empty interrupt request |
| tx_empty | output | 1 | Holding register and shifter both empty |

## Verification
The bench builds the block with the default `OVERSAMPLE`=16 and pulses `tick` on every second clock. With this setting, every bit position lands on a known pulse count, and the 24-pulse stop period can be told apart from the 16- and 32-pulse ones. All four data lengths are crossed with the three parity modes and both stop selects. Each character is written as soon as the previous one leaves the holding register, so the run exercises back-to-back framing and settings that change while a character is shifting.

// File: rtl/async_tx.sv
module async_tx #(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       stop_sel,
  input  logic       brk,
  output logic       txd,
  output logic       hold_empty,
  output logic       irq,
  output logic       tx_empty
);
  localparam int CW = $clog2(2 * OVERSAMPLE) + 1;
  localparam logic [CW-1:0] BIT_LAST = CW'(OVERSAMPLE - 1);
  localparam logic [CW-1:0] STOP_ONE = CW'(OVERSAMPLE);
  localparam logic [CW-1:0] STOP_MID = CW'(OVERSAMPLE + OVERSAMPLE / 2);
  localparam logic [CW-1:0] STOP_TWO = CW'(2 * OVERSAMPLE);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t          st;
  logic [7:0]   hold_q, sh_q;
  logic         hold_full, irq_q, par_q, pen_q;
  logic [1:0]   len_q;
  logic [2:0]   idx_q;
  logic [CW-1:0] cnt_q, stop_q;

  wire [7:0]    mask     = 8'hFF >> (2'd3 - char_len);
  wire          par_in   = (^(hold_q & mask)) ^ ~par_even;
  wire [CW-1:0] stop_in  = !stop_sel ? STOP_ONE : (char_len == 2'd0 ? STOP_MID : STOP_TWO);
  wire          stop_end = (st == S_STOP) && tick && (cnt_q == stop_q - 1'b1);
  wire          load     = hold_full && (st == S_IDLE || stop_end);
  wire          bit_end  = tick && (cnt_q == BIT_LAST);
  wire          last_dat = (idx_q == 3'd4 + {1'b0, len_q});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      hold_q    <= '0;
      sh_q      <= '0;
      hold_full <= 1'b0;
      irq_q     <= 1'b0;
      par_q     <= 1'b0;
      pen_q     <= 1'b0;
      len_q     <= '0;
      idx_q     <= '0;
      cnt_q     <= '0;
      stop_q    <= STOP_ONE;
    end else begin
      if (wr_en) begin
        hold_q    <= wr_data;
        hold_full <= 1'b1;
        irq_q     <= 1'b0;
      end else if (load) begin
        hold_full <= 1'b0;
        irq_q     <= 1'b1;
      end
      if (load) begin
        sh_q   <= hold_q;
        par_q  <= par_in;
        pen_q  <= par_en;
        len_q  <= char_len;
        stop_q <= stop_in;
        idx_q  <= '0;
        cnt_q  <= '0;
        st     <= S_START;
      end else if (st != S_IDLE && tick) begin
        if (st == S_STOP) begin
          cnt_q <= stop_end ? '0 : cnt_q + 1'b1;
          if (stop_end) st <= S_IDLE;
        end else if (bit_end) begin
          cnt_q <= '0;
          case (st)
            S_START: st <= S_DATA;
            S_DATA: begin
              sh_q  <= sh_q >> 1;
              idx_q <= idx_q + 1'b1;
              if (last_dat) st <= pen_q ? S_PAR : S_STOP;
            end
            default: st <= S_STOP;
          endcase
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  wire line = (st == S_START) ? 1'b0 :
              (st == S_DATA)  ? sh_q[0] :
              (st == S_PAR)   ? par_q : 1'b1;

  assign txd        = line & ~brk;
  assign hold_empty = ~hold_full;
  assign irq        = irq_q;
  assign tx_empty   = ~hold_full && (st == S_IDLE);

  p_idle_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty && !brk |-> txd);
  p_stop_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOP) && !brk |-> txd);
  p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) && !tick && !load |=> $stable(cnt_q));
  p_no_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_end && hold_full |=> (st == S_START));
  p_write_fills_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !hold_empty && !irq);
  p_move_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_full && !wr_en && (st == S_IDLE) |=> irq && hold_empty && !tx_empty);
endmodule

// File: tb/async_tx_tb.sv
module async_tx_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, par_en = 1'b0, par_even = 1'b0;
  logic stop_sel = 1'b0, brk = 1'b0, mon_en = 1'b1;
  logic [7:0] wr_data = '0;
  logic [1:0] char_len = '0;
  logic txd, hold_empty, irq, tx_empty;

  async_tx #(.OVERSAMPLE(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .char_len(char_len), .par_en(par_en), .par_even(par_even), .stop_sel(stop_sel),
    .brk(brk), .txd(txd), .hold_empty(hold_empty), .irq(irq), .tx_empty(tx_empty));

  always @(posedge clk) tick <= rst_n ? ~tick : 1'b0;

  typedef struct { logic [7:0] d; int dl; bit pe; bit par; int stop; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic [1:0] l, input bit pe,
                      input bit pev, input bit ss, input bit probe);
    exp_t e;
    logic [7:0] m;
    while (!hold_empty) @(negedge clk);
    m = d & (8'hFF >> (3 - l));
    char_len = l; par_en = pe; par_even = pev; stop_sel = ss;
    wr_data = d; wr_en = 1'b1;
    e.d = m; e.dl = 5 + l; e.pe = pe;
    e.par = pev ? ^m : ~^m;
    e.stop = !ss ? 16 : (l == 0 ? 24 : 32);
    q.push_back(e);
    @(negedge clk);
    wr_en = 1'b0;
    if (probe) begin
      chk("R7 hold_empty after write", hold_empty, 0);
      chk("R7 irq after write", irq, 0);
      chk("R8 tx_empty with full holding", tx_empty, 0);
      @(negedge clk);
      chk("R7 hold_empty after move", hold_empty, 1);
      chk("R7 irq after move", irq, 1);
      chk("R8 tx_empty while shifting", tx_empty, 0);
    end
  endtask

  initial begin
    exp_t e;
    int k, nb;
    logic [7:0] got;
    @(posedge rst_n);
    @(negedge clk);
    forever begin
      while (!(mon_en && txd == 1'b0)) @(negedge clk);
      if (q.size() == 0) begin
        chk("R2 unexpected start bit", 1, 0);
        while (!txd) @(negedge clk);
        continue;
      end
      e = q.pop_front();
      nb = 1 + e.dl + (e.pe ? 1 : 0);
      k = 0; got = '0;
      while (k < 16 * nb) begin
        if (tick) begin
          k++;
          if (k % 16 == 8) begin
            if (k / 16 == 0) chk("R5 start bit low", txd, 0);
            else if (k / 16 <= e.dl) got[k / 16 - 1] = txd;
            else chk("R3 parity bit", txd, e.par);
          end
        end
        @(negedge clk);
      end
      chk("R2 R10 data bits", got, e.d);
      while (!(txd == 1'b0 || tx_empty)) begin
        if (tick) k++;
        @(negedge clk);
      end
      if (txd == 1'b0) chk("R4 R6 stop length before next start", k - 16 * nb, e.stop);
      else chk("R4 stop length", k - 16 * nb, e.stop);
    end
  end

  initial begin
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 txd idle", txd, 1);
    chk("R1 hold_empty", hold_empty, 1);
    chk("R1 irq", irq, 0);
    chk("R1 tx_empty", tx_empty, 1);
    send(8'hA5, 2'd3, 0, 0, 0, 1);
    while (!tx_empty) @(negedge clk);
    for (int l = 0; l < 4; l++)
      for (int pm = 0; pm < 3; pm++)
        for (int s = 0; s < 2; s++)
          send(8'h3C ^ 8'(l * 37 + pm * 11 + s * 91), 2'(l), pm != 0, pm == 1, s[0], 0);
    while (!(tx_empty && q.size() == 0)) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R1 line high when idle", txd, 1);
    chk("R8 tx_empty after all sent", tx_empty, 1);
    mon_en = 1'b0;
    brk = 1'b1;
    @(negedge clk);
    chk("R9 break forces low", txd, 0);
    repeat (20) @(negedge clk);
    chk("R9 break held low", txd, 0);
    brk = 1'b0;
    @(negedge clk);
    chk("R9 line high after break", txd, 1);
    chk("R9 holding untouched by break", hold_empty, 1);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end
endmodule